// File: doc/BRIEF.md
# Register-Mapped GPIO Function Select Bank

This block is a word-addressed register bank that controls 54 general-purpose pins. Each pin holds a 3-bit function code. The code decides whether the pin is a plain input, is driven from its output latch, or is handed to one of six alternate peripherals. Software drives output levels only through write-one-to-set and write-one-to-clear words, so two agents that touch different pins never need a read-modify-write of shared state. Pad levels pass through a synchronizer, and software reads them back through two level words.

The block produces per-pin output-enable, output-value, alternate-enable and a 3-bit alternate index toward an external pad multiplexer. The bus is a single-cycle interface. An access presents an address, a write strobe and write data. Read data is returned combinationally for the presented address from the state held at that moment. The two low address bits are ignored.

Top module: `gpio_fsel_bank`

## Requirements
- R1: Function words sit at byte offsets 0x00 to 0x14. Pin p uses word p/10, bits (p%10)*3 to (p%10)*3+2. A write to a function word replaces every field in it, and a read returns the stored codes.
- R2: Code 1 raises pin_oe_o. Code 0 gives a plain input, with oe low and alt_en low. Codes 4, 5, 6 and 7 select alternates 0 to 3. Code 3 selects alternate 4 and code 2 selects alternate 5. Any of these six codes raises pin_alt_en_o, keeps oe low and puts the alternate number on pin_alt_sel_o[3p+2:3p]. For codes 0 and 1, pin_alt_sel_o is 0.
- R3: A write to 0x1C (pins 0 to 31, bit p) or 0x20 (pins 32 to 53, bit p-32) sets the latch of each pin whose bit is 1. A write to 0x28 or 0x2C, with the same bit layout, clears those latches. Zero bits leave latches unchanged.
- R4: pin_out_o always shows the latch, whatever the function code. Changing a pin to code 1 drives the previously latched value from the next cycle.
- R5: Level words sit at 0x34 (pins 0 to 31) and 0x38 (pins 32 to 53, at bit p-32). A change on pin_level_i appears in the read data after exactly two rising clock edges.
- R6: The following read as zero: bits 30 and 31 of function words, bits 12 to 31 of word 0x14, bits 22 to 31 of 0x38, the set and clear words, and every other unmapped word. Writes to unmapped words change nothing.
- R7: After reset all function codes are 0 (input), all latches are 0 and all synchronized levels are 0.
- R8: A read presented in the same cycle as a write to the same word returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Byte address of the access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| pin_level_i | input | 54 | Raw pad levels |
| pin_oe_o | output | 54 | Output enable per pin |
| pin_out_o | output | 54 | Output latch per pin |
| pin_alt_en_o | output | 54 | Pin is owned by an alternate peripheral |
| pin_alt_sel_o | output | 162 | Alternate index 0 to 5, 3 bits per pin |

## Verification
Because the read path is combinational, a write and a read of the same word land in the same cycle. The bench provokes this by writing function and level words while it compares read data against a model that still holds the pre-write contents. A second pairing is a level change travelling through the synchronizer while set and clear writes alter the latches. The random phase mixes both with random words that include unmapped ones. Every cycle, each output is compared with the behavioural model, so a write that leaks into an unrelated pin or arrives one edge early is seen in the cycle it happens.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;

  localparam int unsigned FN_CODE_W = 3;

  typedef enum logic [FN_CODE_W-1:0] {
    FN_IN   = 3'd0,
    FN_OUT  = 3'd1,
    FN_ALT5 = 3'd2,
    FN_ALT4 = 3'd3,
    FN_ALT0 = 3'd4,
    FN_ALT1 = 3'd5,
    FN_ALT2 = 3'd6,
    FN_ALT3 = 3'd7
  } fn_code_e;

  // word indices (byte offset / 4)
  localparam int unsigned SET_WORD = 7;
  localparam int unsigned CLR_WORD = 10;
  localparam int unsigned LEV_WORD = 13;

  function automatic logic [FN_CODE_W-1:0] alt_index(input logic [FN_CODE_W-1:0] code);
    logic [FN_CODE_W-1:0] idx;
    case (code)
      FN_ALT0: idx = 3'd0;
      FN_ALT1: idx = 3'd1;
      FN_ALT2: idx = 3'd2;
      FN_ALT3: idx = 3'd3;
      FN_ALT4: idx = 3'd4;
      FN_ALT5: idx = 3'd5;
      default: idx = 3'd0;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/gpio_fn_store.sv
module gpio_fn_store
  import gpio_fsel_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PPF      = 10,
  parameter int unsigned WIDX_W   = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [WIDX_W-1:0]             widx_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic [NUM_PINS*FN_CODE_W-1:0] fn_o
);

  localparam int unsigned USED_W = PPF * FN_CODE_W;

  logic [FN_CODE_W-1:0] fn_q [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int unsigned W = p / PPF;
    localparam int unsigned S = (p % PPF) * FN_CODE_W;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fn_q[p] <= FN_IN;
      end else if (wr_en_i && (widx_i == WIDX_W'(W))) begin
        fn_q[p] <= wr_data_i[S +: FN_CODE_W];
      end
    end

    assign fn_o[p*FN_CODE_W +: FN_CODE_W] = fn_q[p];
  end

  // fields that no pin maps to are simply never driven
  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (widx_i == WIDX_W'(p / PPF)) begin
        rd_data_o[(p % PPF)*FN_CODE_W +: FN_CODE_W] = fn_q[p];
      end
    end
  end

  if (DATA_W > USED_W) begin : g_pad
    logic unused_pad_bits;
    assign unused_pad_bits = ^wr_data_i[DATA_W-1:USED_W];
  end

  // R1: function state only moves on a function-word write
  a_r1_fn_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(fn_o));

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WIDX_W   = 6,
  parameter int unsigned SET_BASE = 7,
  parameter int unsigned CLR_BASE = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [WIDX_W-1:0]   widx_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_PINS-1:0] latch_o
);

  logic [NUM_PINS-1:0] set_mask, clr_mask, latch_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mask
    localparam int unsigned B = p / DATA_W;
    localparam int unsigned K = p % DATA_W;
    assign set_mask[p] = we_i && (widx_i == WIDX_W'(SET_BASE + B)) && wdata_i[K];
    assign clr_mask[p] = we_i && (widx_i == WIDX_W'(CLR_BASE + B)) && wdata_i[K];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
    end else begin
      latch_q <= (latch_q | set_mask) & ~clr_mask;
    end
  end

  assign latch_o = latch_q;

  // R3: every pin named in a set write is high afterwards
  a_r3_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mask != '0) |=> ((latch_q & $past(set_mask)) == $past(set_mask)));

  // R3: every pin named in a clear write is low afterwards
  a_r3_clr_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mask != '0) |=> ((latch_q & $past(clr_mask)) == '0));

  // R3: pins not named keep their value
  a_r3_others_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & ~$past(set_mask | clr_mask)) ==
              ($past(latch_q) & ~$past(set_mask | clr_mask))));

endmodule

// File: rtl/gpio_level_sync.sv
module gpio_level_sync #(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] level_i,
  output logic [NUM_PINS-1:0] level_o
);

  logic [NUM_PINS-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= level_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign level_o = stg_q[STAGES-1];

  // edges seen since reset, saturating; only feeds the check below
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= 2'd0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  if (STAGES == 2) begin : g_chk
    // R5: synchronized level equals the pad two edges earlier
    a_r5_two_edge_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd2) |-> (level_o == $past(level_i, 2)));
  end

endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
  import gpio_fsel_pkg::*;
#(
  parameter int unsigned NUM_PINS       = 54,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned PINS_PER_FWORD = 10,
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic                          bus_we_i,
  input  logic [DATA_W-1:0]             bus_wdata_i,
  output logic [DATA_W-1:0]             bus_rdata_o,
  input  logic [NUM_PINS-1:0]           pin_level_i,
  output logic [NUM_PINS-1:0]           pin_oe_o,
  output logic [NUM_PINS-1:0]           pin_out_o,
  output logic [NUM_PINS-1:0]           pin_alt_en_o,
  output logic [NUM_PINS*FN_CODE_W-1:0] pin_alt_sel_o
);

  localparam int unsigned NUM_FWORDS = (NUM_PINS + PINS_PER_FWORD - 1) / PINS_PER_FWORD;
  localparam int unsigned NUM_BANKS  = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int unsigned WIDX_W     = ADDR_W - 2;

  logic [WIDX_W-1:0]             widx;
  logic                          fsel_hit;
  logic [DATA_W-1:0]             fn_rd;
  logic [NUM_PINS*FN_CODE_W-1:0] fn_flat;
  logic [NUM_PINS-1:0]           lev_sync;
  logic [DATA_W-1:0]             lev_word [NUM_BANKS];
  logic                          unused_byte_sel;

  assign widx            = bus_addr_i[ADDR_W-1:2];
  assign unused_byte_sel = ^bus_addr_i[1:0];
  assign fsel_hit        = widx < WIDX_W'(NUM_FWORDS);

  gpio_fn_store #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .PPF      (PINS_PER_FWORD),
    .WIDX_W   (WIDX_W)
  ) u_fn_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (bus_we_i && fsel_hit),
    .widx_i    (widx),
    .wr_data_i (bus_wdata_i),
    .rd_data_o (fn_rd),
    .fn_o      (fn_flat)
  );

  gpio_out_latch #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .WIDX_W   (WIDX_W),
    .SET_BASE (SET_WORD),
    .CLR_BASE (CLR_WORD)
  ) u_out_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .widx_i  (widx),
    .wdata_i (bus_wdata_i),
    .latch_o (pin_out_o)
  );

  gpio_level_sync #(
    .NUM_PINS (NUM_PINS),
    .STAGES   (SYNC_STAGES)
  ) u_level_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (pin_level_i),
    .level_o (lev_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_dec
    logic [FN_CODE_W-1:0] code;
    assign code                                  = fn_flat[p*FN_CODE_W +: FN_CODE_W];
    assign pin_oe_o[p]                           = (code == FN_OUT);
    assign pin_alt_en_o[p]                       = code[2] | code[1];
    assign pin_alt_sel_o[p*FN_CODE_W +: FN_CODE_W] = alt_index(code);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lev
    localparam int unsigned LO = b * DATA_W;
    localparam int unsigned N  = (NUM_PINS - LO < DATA_W) ? (NUM_PINS - LO) : DATA_W;
    if (N < DATA_W) begin : g_part
      assign lev_word[b] = {{(DATA_W-N){1'b0}}, lev_sync[LO +: N]};
    end else begin : g_full
      assign lev_word[b] = lev_sync[LO +: N];
    end
  end

  // set and clear words are write-only and fall through to zero
  always_comb begin
    bus_rdata_o = '0;
    if (fsel_hit) bus_rdata_o = fn_rd;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (widx == WIDX_W'(LEV_WORD + b)) bus_rdata_o = lev_word[b];
    end
  end

  // R2: a pin is never both driven from its latch and handed to a peripheral
  a_r2_oe_alt_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & pin_alt_en_o) == '0);

  // R2: pins not owned by a peripheral present alternate index zero
  a_r2_idle_sel_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_alt_en_o == '0) |-> (pin_alt_sel_o == '0));

endmodule

// File: tb/gpio_fsel_bank_bench.sv
`timescale 1ns/1ps
module gpio_fsel_bank_bench;

  localparam int NP = 54;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   addr = '0;
  logic         we = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [NP-1:0] lvl = '0;
  logic [NP-1:0] oe, out, alten;
  logic [NP*3-1:0] altsel;

  always #5 clk = ~clk;

  gpio_fsel_bank u_gpio_fsel_bank (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .bus_addr_i    (addr),
    .bus_we_i      (we),
    .bus_wdata_i   (wdata),
    .bus_rdata_o   (rdata),
    .pin_level_i   (lvl),
    .pin_oe_o      (oe),
    .pin_out_o     (out),
    .pin_alt_en_o  (alten),
    .pin_alt_sel_o (altsel)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural model
  int m_fn  [NP];
  bit m_lat [NP];
  bit m_s0  [NP];
  bit m_s1  [NP];

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_fn[p] = 0; m_lat[p] = 0; m_s0[p] = 0; m_s1[p] = 0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_fn[p] = 0; m_lat[p] = 0; m_s0[p] = 0; m_s1[p] = 0;
      end
    end else begin
      int w;
      w = int'(addr) / 4;
      for (int p = 0; p < NP; p++) begin
        m_s1[p] = m_s0[p];
        m_s0[p] = lvl[p];
      end
      if (we) begin
        if (w < 6) begin
          for (int j = 0; j < 10; j++)
            if (w*10 + j < NP) m_fn[w*10 + j] = int'((wdata >> (j*3)) & 32'h7);
        end else if (w == 7 || w == 8) begin
          for (int k = 0; k < 32; k++)
            if ((w-7)*32 + k < NP && wdata[k]) m_lat[(w-7)*32 + k] = 1;
        end else if (w == 10 || w == 11) begin
          for (int k = 0; k < 32; k++)
            if ((w-10)*32 + k < NP && wdata[k]) m_lat[(w-10)*32 + k] = 0;
        end
      end
    end
  end

  function automatic logic [2:0] alt_of(int c);
    case (c)
      4: return 3'd0;
      5: return 3'd1;
      6: return 3'd2;
      7: return 3'd3;
      3: return 3'd4;
      2: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [31:0] r;
    int w;
    r = '0;
    w = int'(a) / 4;
    if (w < 6) begin
      for (int j = 0; j < 10; j++)
        if (w*10 + j < NP) r[j*3 +: 3] = 3'(m_fn[w*10 + j]);
    end else if (w == 13 || w == 14) begin
      for (int k = 0; k < 32; k++)
        if ((w-13)*32 + k < NP) r[k] = m_s1[(w-13)*32 + k];
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [191:0] act, logic [191:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [NP-1:0]   e_oe, e_out, e_en;
    logic [NP*3-1:0] e_sel;
    logic [31:0]     e_rd;
    int              w;
    string           tag;
    for (int p = 0; p < NP; p++) begin
      e_oe[p]          = (m_fn[p] == 1);
      e_en[p]          = (m_fn[p] >= 2);
      e_sel[p*3 +: 3]  = alt_of(m_fn[p]);
      e_out[p]         = m_lat[p];
    end
    e_rd = exp_rd(addr);
    w = int'(addr) / 4;
    if (w < 6)                  tag = we ? "R8" : "R1";
    else if (w == 13 || w == 14) tag = "R5";
    else                        tag = "R6";
    chk(oe == e_oe, "R2", "oe", 192'(oe), 192'(e_oe));
    chk(alten == e_en, "R2", "alt_en", 192'(alten), 192'(e_en));
    chk(altsel == e_sel, "R2", "alt_sel", 192'(altsel), 192'(e_sel));
    chk(out == e_out, "R4", "out", 192'(out), 192'(e_out));
    chk(rdata == e_rd, tag, "rdata", 192'(rdata), 192'(e_rd));
  endtask

  task automatic step(input logic [7:0] a, input bit w, input logic [31:0] d,
                      input logic [NP-1:0] l);
    @(negedge clk);
    addr = a; we = w; wdata = d; lvl = l;
    #1;
    compare_all();
  endtask

  task automatic bus(input logic [7:0] a, input bit w, input logic [31:0] d);
    step(a, w, d, lvl);
  endtask

  function automatic logic [31:0] pack10(int c0, int c1, int c2, int c3, int c4,
                                         int c5, int c6, int c7, int c8, int c9);
    int c [10];
    logic [31:0] r;
    c = '{c0, c1, c2, c3, c4, c5, c6, c7, c8, c9};
    r = '0;
    for (int j = 0; j < 10; j++) r[j*3 +: 3] = 3'(c[j]);
    return r;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] old;
    logic [NP-1:0] l2;
    lvl = 54'h2A_5A5A_0F0F_1234;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: reset state
    bus(8'h34, 0, 0);
    chk(rdata == 32'h0, "R7", "level after reset", 192'(rdata), 192'h0);
    chk(oe == '0 && alten == '0 && out == '0, "R7", "pins after reset",
        192'({oe, out}), 192'h0);
    bus(8'h00, 0, 0);
    chk(rdata == 32'h0, "R7", "fsel after reset", 192'(rdata), 192'h0);

    // R1/R2: all codes on word 0
    bus(8'h00, 1, pack10(0, 1, 2, 3, 4, 5, 6, 7, 0, 1));
    bus(8'h00, 0, 0);
    chk(rdata == pack10(0, 1, 2, 3, 4, 5, 6, 7, 0, 1), "R1", "word0 readback",
        192'(rdata), 192'(pack10(0, 1, 2, 3, 4, 5, 6, 7, 0, 1)));
    chk(altsel[29:0] == {3'd0, 3'd0, 3'd3, 3'd2, 3'd1, 3'd0, 3'd4, 3'd5, 3'd0, 3'd0},
        "R2", "alt index map", 192'(altsel[29:0]),
        192'({3'd0, 3'd0, 3'd3, 3'd2, 3'd1, 3'd0, 3'd4, 3'd5, 3'd0, 3'd0}));
    chk(oe[9:0] == 10'b10_0000_0010 && alten[9:0] == 10'b00_1111_1100, "R2",
        "oe/alt_en map", 192'({oe[9:0], alten[9:0]}), 192'({10'b10_0000_0010, 10'b00_1111_1100}));

    // R6: pad bits of function words
    bus(8'h14, 1, 32'hFFFF_FFFF);
    bus(8'h14, 0, 0);
    chk(rdata == 32'h0000_0FFF, "R6", "word5 pad", 192'(rdata), 192'h0000_0FFF);
    bus(8'h04, 1, 32'hFFFF_FFFF);
    bus(8'h04, 0, 0);
    chk(rdata == 32'h3FFF_FFFF, "R6", "word1 top bits", 192'(rdata), 192'h3FFF_FFFF);

    // R8: read during write returns old contents
    bus(8'h04, 1, 32'h1111_1111);
    chk(rdata == 32'h3FFF_FFFF, "R8", "read during write", 192'(rdata), 192'h3FFF_FFFF);
    bus(8'h04, 0, 0);
    chk(rdata == 32'h1111_1111, "R1", "after write", 192'(rdata), 192'h1111_1111);

    // R3: set and clear
    bus(8'h1C, 1, 32'hA5A5_A5A5);
    bus(8'h00, 0, 0);
    chk(out[31:0] == 32'hA5A5_A5A5, "R3", "set bank0", 192'(out[31:0]), 192'hA5A5_A5A5);
    bus(8'h1C, 1, 32'h0);
    bus(8'h28, 1, 32'h0000_00FF);
    bus(8'h00, 0, 0);
    chk(out[31:0] == 32'hA5A5_A500, "R3", "clear bank0", 192'(out[31:0]), 192'hA5A5_A500);
    bus(8'h20, 1, 32'hFFFF_FFFF);
    bus(8'h1C, 0, 0);
    chk(rdata == 32'h0 && out[53:32] == 22'h3F_FFFF, "R3", "set bank1 / write-only read",
        192'({rdata, out[53:32]}), 192'({32'h0, 22'h3F_FFFF}));
    bus(8'h2C, 1, 32'h0000_0100);
    bus(8'h28, 1, 32'hFFFF_FFFF);
    bus(8'h00, 0, 0);
    chk(out == {22'h3F_FEFF, 32'h0}, "R3", "clear bank1", 192'(out), 192'({22'h3F_FEFF, 32'h0}));

    // R4: latch held while input, driven on switch to output
    bus(8'h10, 1, 32'h0);
    bus(8'h2C, 1, 32'hFFFF_FFFF);
    bus(8'h20, 1, 32'h0000_0100);
    bus(8'h00, 0, 0);
    chk(out[40] == 1'b1 && oe[40] == 1'b0, "R4", "latched while input",
        192'({out[40], oe[40]}), 192'(2'b10));
    bus(8'h10, 1, 32'h1);
    bus(8'h00, 0, 0);
    chk(out[40] == 1'b1 && oe[40] == 1'b1, "R4", "driven after switch",
        192'({out[40], oe[40]}), 192'(2'b11));

    // R5: two-edge synchronizer
    step(8'h34, 0, 0, 54'h15_0000_DEAD_BEEF);
    old = rdata;
    bus(8'h34, 0, 0);
    chk(rdata == old, "R5", "one edge not yet visible", 192'(rdata), 192'(old));
    bus(8'h34, 0, 0);
    chk(rdata == 32'hDEAD_BEEF, "R5", "bank0 after two edges", 192'(rdata), 192'hDEAD_BEEF);
    bus(8'h38, 0, 0);
    chk(rdata == 32'h0015_0000, "R5", "bank1 after two edges", 192'(rdata), 192'h0015_0000);

    // R6: unmapped writes ignored
    bus(8'h18, 1, 32'hFFFF_FFFF);
    bus(8'hFC, 1, 32'hFFFF_FFFF);
    bus(8'h3C, 1, 32'hFFFF_FFFF);
    bus(8'hFC, 0, 0);
    chk(rdata == 32'h0, "R6", "unmapped read", 192'(rdata), 192'h0);

    // random mix: writes, same-cycle reads, level churn
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = ($urandom_range(0, 9) == 0) ? 8'(($urandom_range(0, 63)) << 2)
                                      : 8'(($urandom_range(0, 16)) << 2);
      l2 = lvl;
      if (i % 3 == 0) l2 = {$urandom, $urandom};
      step(a, bit'($urandom_range(0, 1)), $urandom, l2);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule